// File: doc/BRIEF.md
# Host Register Port with Power-Fail Lockout

This block is the host side of a small peripheral: an asynchronous microprocessor port with active-low select, read and write strobes, a 5-bit address and an 8-bit data path. The data path is bidirectional at the pin. It is carried here as a separate input, output and output-enable, and a pad ring turns these into the tristate pin. Behind the port sits a stub register file of 32 bytes, so that reads and writes can be observed end to end.

A power-fail input comes from external supply detection logic and is active low. Once it is seen low, the port stops accepting new bus cycles. A cycle that is already running is allowed to finish. After a delay counted in slow ticks, the port enters a lockout state, and it stays there until a reset or a power-restored pulse. The delay is a default length, or a shorter length supplied on a delay input. The read data drive is withdrawn as soon as the power-fail input goes low. In single-supply operation the power-fail input is disregarded.

Top module: `hostport_lockout`

## Requirements
- R1: After reset, every register reads 0x00, `locked` is 0 and `bus_oe` is 0.
- R2: A write takes effect only while `cs_n` and `wr_n` are both low. The byte on `bus_din` is stored at `addr` when `wr_n` or `cs_n` returns high. Pulsing `wr_n` while `cs_n` is high changes no register.
- R3: A read cycle (`cs_n` and `rd_n` low) drives `bus_oe` high and drives the byte stored at `addr` on `bus_dout`. `bus_oe` is low outside read cycles.
- R4: While power fail is active (sampled low, single-supply off) or lockout holds, no new read or write cycle starts. A write attempted then leaves the register unchanged, and a read attempted then leaves `bus_oe` low.
- R5: A write cycle that is already in progress when power fail arrives still stores its byte.
- R6: During a read cycle, `bus_oe` falls in the same cycle that `pfail_n` goes low. This happens combinationally, without synchronisation.
- R7: With `dly_prog` = 0, `locked` rises after exactly DEF_TICKS (default 31) `tick` pulses, counted from the first synchronised low of `pfail_n`. It does not rise after one pulse fewer.
- R8: With `dly_prog` = 1, the lockout count is `dly_ticks` pulses. A value of 0 is treated as 1.
- R9: If `pfail_n` returns high before the count is reached, no lockout occurs, and the next power fail starts counting from zero.
- R10: While `single_supply` is 1, `pfail_n` has no effect: no lockout, and bus cycles proceed.
- R11: Once set, `locked` stays set after `pfail_n` returns high. It clears only on reset, or on a `restore` pulse while power fail is inactive.
- R12: If the count is reached during a bus cycle, `locked` rises only after that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle slow time-base pulse for the lockout delay |
| single_supply | input | 1 | 1: power-fail input disregarded |
| pfail_n | input | 1 | Power-fail indication, active low, asynchronous |
| restore | input | 1 | Power-restored pulse, clears lockout |
| dly_prog | input | 1 | 1: use `dly_ticks` as the lockout delay |
| dly_ticks | input | 6 | Programmed lockout delay in ticks |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 5 | Register address |
| bus_din | input | 8 | Data from the host bus |
| bus_dout | output | 8 | Data to the host bus |
| bus_oe | output | 1 | Drive enable for the data pins |
| locked | output | 1 | Lockout in effect |

## Verification
The lockout timer can expire in the same cycle that a bus cycle is still open. The bench provokes this by holding a write strobe low while the power-fail input falls and the full tick count is delivered. It then judges that `locked` stays low until the strobe is released, and that the held write still lands in the register file. The second collision is a power-fail edge in the middle of a read. Here the bench checks that the output enable drops within the same clock period. It also checks that the read cycle itself is not aborted: the enable returns if power comes back before the synchroniser registers the low.

// File: rtl/hostport_lockout.sv
module hostport_lockout #(
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int CNT_W     = 6,
  parameter int DEF_TICKS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             single_supply,
  input  logic             pfail_n,
  input  logic             restore,
  input  logic             dly_prog,
  input  logic [CNT_W-1:0] dly_ticks,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    bus_din,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_oe,
  output logic             locked
);
  localparam int DEPTH = 1 << AW;
  localparam logic [CNT_W-1:0] DEF_LIM = CNT_W'(DEF_TICKS);

  typedef enum logic [1:0] {C_IDLE, C_RD, C_WR} cyc_t;

  logic [3:0] sy1, sy2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
    end else begin
      sy1 <= {pfail_n, cs_n, rd_n, wr_n};
      sy2 <= sy1;
    end

  wire pf_s = sy2[3];
  wire cs_s = sy2[2];
  wire rd_s = sy2[1];
  wire wr_s = sy2[0];

  wire pf_act  = !pf_s && !single_supply;
  wire blocked = pf_act || locked;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  assign limit = !dly_prog ? DEF_LIM :
                 (dly_ticks == '0) ? CNT_W'(1) : dly_ticks;
  wire expired = cnt >= limit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (!pf_act || locked) cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;

  cyc_t cyc;
  logic [AW-1:0] cad;
  logic [DW-1:0] wdat;
  logic [DW-1:0] mem [DEPTH];

  wire commit = (cyc == C_WR) && (cs_s || wr_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) locked <= 1'b0;
    else if (restore && !pf_act) locked <= 1'b0;
    else if (pf_act && expired && cyc == C_IDLE) locked <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cyc  <= C_IDLE;
      cad  <= '0;
      wdat <= '0;
    end else begin
      case (cyc)
        C_IDLE:
          if (!cs_s && !blocked) begin
            if (!wr_s) begin
              cyc  <= C_WR;
              cad  <= addr;
              wdat <= bus_din;
            end else if (!rd_s) begin
              cyc <= C_RD;
              cad <= addr;
            end
          end
        C_RD:
          if (cs_s || rd_s) cyc <= C_IDLE;
        C_WR:
          if (commit) cyc <= C_IDLE;
          else wdat <= bus_din;
        default: cyc <= C_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[cad] <= wdat;
    end

  assign bus_dout = mem[cad];
  assign bus_oe   = (cyc == C_RD) && !cs_s && !rd_s
                    && (pfail_n || single_supply);

  p_start_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc == C_WR) |-> !$past(pf_act) && !$past(locked));

  p_lock_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pf_act));

  p_lock_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> cyc == C_IDLE);

  p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !restore |=> locked);

  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(single_supply));

  p_oe_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !locked);
endmodule

// File: tb/hostport_lockout_test.sv
module hostport_lockout_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, tick = 0, single_supply = 0, pfail_n = 1, restore = 0;
  logic dly_prog = 0;
  logic [5:0] dly_ticks = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [4:0] addr = 0;
  logic [7:0] bus_din = 0;
  logic [7:0] bus_dout;
  logic bus_oe, locked;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hostport_lockout uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .single_supply(single_supply),
    .pfail_n(pfail_n), .restore(restore), .dly_prog(dly_prog),
    .dly_ticks(dly_ticks), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .locked(locked)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1; step(1); tick = 0; step(3);
  endtask

  task automatic do_restore();
    restore = 1; step(1); restore = 0; step(3);
  endtask

  task automatic wr_cyc(input logic [4:0] a, input logic [7:0] d);
    addr = a; bus_din = d; cs_n = 0; wr_n = 0; step(4);
    wr_n = 1; step(4); cs_n = 1; step(3);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string req);
    addr = a; cs_n = 0; rd_n = 0; step(5);
    chk(bus_oe === 1'b1, req, bus_oe, 1);
    chk(bus_dout === exp, req, bus_dout, exp);
    rd_n = 1; cs_n = 1; step(4);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic lock_run(input int lim, input string req);
    pfail_n = 0; step(4);
    for (int i = 1; i <= lim; i++) begin
      pulse_tick();
      if (i == lim - 1) chk(locked === 1'b0, req, locked, 0);
    end
    step(2);
    chk(locked === 1'b1, req, locked, 1);
    pfail_n = 1; step(4); do_restore();
    chk(locked === 1'b0, "R11", locked, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(2);
    // R1 reset state
    chk(locked === 1'b0, "R1", locked, 0);
    chk(bus_oe === 1'b0, "R1", bus_oe, 0);
    rd_chk(5'd17, 8'h00, "R1");

    // R2/R3 full sweep
    for (int a = 0; a < 32; a++) wr_cyc(5'(a), pat(a));
    for (int a = 0; a < 32; a++) rd_chk(5'(a), pat(a), "R3");
    chk(bus_oe === 1'b0, "R3", bus_oe, 0);

    // R2 write strobe without select
    addr = 5'd4; bus_din = 8'hEE; wr_n = 0; step(4); wr_n = 1; step(4);
    rd_chk(5'd4, pat(4), "R2");

    // R4 write attempted during power fail is ignored
    pfail_n = 0; step(4);
    wr_cyc(5'd3, 8'hC3);
    addr = 5'd3; cs_n = 0; rd_n = 0; step(5);
    chk(bus_oe === 1'b0, "R4", bus_oe, 0);
    rd_n = 1; cs_n = 1; step(3);
    pfail_n = 1; step(4);
    chk(locked === 1'b0, "R9", locked, 0);
    rd_chk(5'd3, pat(3), "R4");

    // R6 enable drops at once on power fail during read
    addr = 5'd6; cs_n = 0; rd_n = 0; step(5);
    chk(bus_oe === 1'b1, "R6", bus_oe, 1);
    pfail_n = 0; #1;
    chk(bus_oe === 1'b0, "R6", bus_oe, 0);
    pfail_n = 1; #1;
    chk(bus_oe === 1'b1, "R6", bus_oe, 1);
    rd_n = 1; cs_n = 1; step(4);

    // R7 default delay
    lock_run(31, "R7");

    // R8 programmed delays, 0 counts as 1
    dly_prog = 1;
    dly_ticks = 6'd0; lock_run(1, "R8");
    dly_ticks = 6'd1; lock_run(1, "R8");
    dly_ticks = 6'd2; lock_run(2, "R8");
    dly_ticks = 6'd7; lock_run(7, "R8");
    dly_ticks = 6'd20; lock_run(20, "R8");
    dly_prog = 0;

    // R9 early recovery restarts the count
    pfail_n = 0; step(4);
    for (int i = 0; i < 20; i++) pulse_tick();
    pfail_n = 1; step(4);
    chk(locked === 1'b0, "R9", locked, 0);
    lock_run(31, "R9");

    // R11 lock persists, restore needs power back
    pfail_n = 0; step(4);
    for (int i = 0; i < 31; i++) pulse_tick();
    step(2);
    do_restore();
    chk(locked === 1'b1, "R11", locked, 1);
    pfail_n = 1; step(6);
    for (int i = 0; i < 3; i++) pulse_tick();
    chk(locked === 1'b1, "R11", locked, 1);
    wr_cyc(5'd8, 8'h77);
    do_restore();
    chk(locked === 1'b0, "R11", locked, 0);
    rd_chk(5'd8, pat(8), "R4");

    // R12/R5 lock waits for open write, which still lands
    addr = 5'd9; bus_din = 8'hA5; cs_n = 0; wr_n = 0; step(4);
    pfail_n = 0; step(4);
    for (int i = 0; i < 33; i++) pulse_tick();
    chk(locked === 1'b0, "R12", locked, 0);
    wr_n = 1; step(6);
    chk(locked === 1'b1, "R12", locked, 1);
    cs_n = 1; step(3);
    pfail_n = 1; step(4); do_restore();
    rd_chk(5'd9, 8'hA5, "R5");

    // R10 single supply
    single_supply = 1; pfail_n = 0; step(4);
    for (int i = 0; i < 40; i++) pulse_tick();
    chk(locked === 1'b0, "R10", locked, 0);
    wr_cyc(5'd12, 8'h3C);
    rd_chk(5'd12, 8'h3C, "R10");
    pfail_n = 1; step(4); single_supply = 0; step(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule